// File: doc/BRIEF.md
# Indirect Gate Schedule Access Controller

This block sits on the register side of a time-aware traffic gate. Software reaches a double-banked gate list memory and four schedule parameter words through two registers, not through direct addressing. It first loads a 32-bit data holding register. It then writes a control word that carries an entry address, a direction flag, a target flag and a start bit. The block performs one read or write and drops the start bit when the access is complete. A read leaves its result in the data holding register.

The list has two banks. Software programs one bank while the scheduler reads the other through a dedicated read port. A swap request exchanges the two banks, and a status bit shows which bank software currently owns. A select bit in the control word is driven out to choose which of two consumer functions is served by the list memory.

Top module: `gate_list_ctrl`

## Requirements
- R1: After reset, the data holding register (offset 0), the control register (offset 1) and the status register (offset 2) all read zero, and `sw_bank`, `list_user` and `bus_rvalid` are 0.
- R2: Writing the control register with bit 0 (start) set launches one access. Control bit 1 set means write and clear means read. Bits 15:8 hold the address. Start reads back as 1 in the two cycles after launch and as 0 from the third cycle on.
- R3: A list entry has the interval in bits 23:0 and one gate bit per gate above it in bits 27:24, gate 3 highest. On both write and read, bits above the gate field are forced to zero. A list read places the entry in the data holding register.
- R4: When control bit 2 is set, the access targets the parameter words: index 0 base time, 1 cycle time, 2 time extension, 3 list length. These words hold all 32 bits and are separate from the list memory.
- R5: A control register write that arrives while start reads 1 is ignored. It launches nothing and leaves the control fields unchanged.
- R6: A data holding register write that arrives while start reads 1 is ignored. The access in flight uses the earlier value.
- R7: A list address at or above the list depth, or a parameter index above 3, is ignored on write and reads as zero. No aliased entry changes.
- R8: Status bit 0 and `sw_bank` name the bank that software owns. A one-cycle `swap_req` toggles the owner. Software accesses go to the owned bank, and `sched_rdata` returns the other bank's entry at `sched_addr` one cycle after the address is applied.
- R9: Control bit 3 is stored on every accepted control write, with or without start, and drives `list_user`.
- R10: Every `bus_rd` produces a `bus_rvalid` pulse on the next cycle, with the addressed register in `bus_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | RA_W | Register word offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after `bus_rd` |
| swap_req | input | 1 | Exchange software and scheduler banks |
| sched_addr | input | clog2(DEPTH) | Scheduler list read address |
| sched_rdata | output | 32 | Scheduler list entry, masked |
| sw_bank | output | 1 | Bank currently owned by software |
| list_user | output | 1 | Consumer function selected for the list memory |

## Verification
The bench builds the block with a list depth of 8, four gates and a 24-bit interval. With a depth of 8, address 8 aliases entry 0 and address 255 aliases entry 7, so out-of-range writes that leak through the index bits would show up in a readback. With four gates, the top nibble is reserved, so masking is visible when all-ones upper bits are written. These values also make it possible to follow a single entry through two swaps, from the software port and from the scheduler port.

// File: rtl/gl_pkg.sv
package gl_pkg;
  // register word offsets
  localparam int REG_DATA = 0;
  localparam int REG_CTRL = 1;
  localparam int REG_STAT = 2;
  // control word bit positions
  localparam int C_START  = 0;
  localparam int C_WRITE  = 1;
  localparam int C_PARAM  = 2;
  localparam int C_SEL    = 3;
  localparam int C_ADDR   = 8;
  localparam int C_ADDR_W = 8;
  // schedule parameter words
  localparam int PARAM_N  = 4;
  typedef enum logic [1:0] {PH_IDLE = 2'd0, PH_ISSUE = 2'd1, PH_DONE = 2'd2} gl_phase_t;
endpackage

// File: rtl/gl_bank_ram.sv
module gl_bank_ram #(
  parameter int DEPTH = 16,
  parameter int W     = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          a_we,
  input  logic [AW:0]   a_addr,
  input  logic [W-1:0]  a_wdata,
  output logic [W-1:0]  a_q,
  input  logic [AW:0]   b_addr,
  output logic [W-1:0]  b_q
);
  // both banks in one array; top address bit picks the bank
  logic [W-1:0] mem [2*DEPTH];

  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    a_q <= mem[a_addr];
  end

  always_ff @(posedge clk) begin
    b_q <= mem[b_addr];
  end
endmodule

// File: rtl/gl_param_file.sv
module gl_param_file #(
  parameter int N  = 4,
  parameter int W  = 32,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [IW-1:0] idx,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  q
);
  logic [W-1:0] regs [N];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) regs[i] <= '0;
      q <= '0;
    end else begin
      if (we) regs[idx] <= wdata;
      q <= regs[idx];
    end
  end
endmodule

// File: rtl/gate_list_ctrl.sv
module gate_list_ctrl
  import gl_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int GATES = 4,
  parameter int TI_W  = 24,
  parameter int RA_W  = 4,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [RA_W-1:0] bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  output logic            bus_rvalid,
  input  logic            swap_req,
  input  logic [AW-1:0]   sched_addr,
  output logic [31:0]     sched_rdata,
  output logic            sw_bank,
  output logic            list_user
);
  localparam int ENT_W = GATES + TI_W;
  localparam logic [31:0] ENT_MASK = 32'((64'd1 << ENT_W) - 64'd1);
  localparam int PIW = $clog2(PARAM_N);

  gl_phase_t             phase;
  logic [31:0]           data_hold;
  logic                  c_write, c_param, c_sel, op_bank;
  logic [C_ADDR_W-1:0]   c_addr;
  logic                  busy, ctrl_wr, data_wr, launch;
  logic                  list_ok, par_ok, ram_we, par_we;
  logic [31:0]           ram_q, ram_bq, par_q;

  assign busy    = (phase != PH_IDLE);
  assign ctrl_wr = bus_wr && (bus_addr == RA_W'(REG_CTRL)) && !busy;
  assign data_wr = bus_wr && (bus_addr == RA_W'(REG_DATA)) && !busy;
  assign launch  = ctrl_wr && bus_wdata[C_START];
  assign list_ok = {24'b0, c_addr} < 32'(DEPTH);
  assign par_ok  = {24'b0, c_addr} < 32'(PARAM_N);
  assign ram_we  = (phase == PH_ISSUE) && c_write && !c_param && list_ok;
  assign par_we  = (phase == PH_ISSUE) && c_write && c_param && par_ok;

  // control fields, access sequencer and bank ownership
  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      c_write <= 1'b0;
      c_param <= 1'b0;
      c_sel   <= 1'b0;
      c_addr  <= '0;
      op_bank <= 1'b0;
      sw_bank <= 1'b0;
    end else begin
      if (swap_req) sw_bank <= ~sw_bank;
      if (ctrl_wr) begin
        c_write <= bus_wdata[C_WRITE];
        c_param <= bus_wdata[C_PARAM];
        c_sel   <= bus_wdata[C_SEL];
        c_addr  <= bus_wdata[C_ADDR +: C_ADDR_W];
      end
      case (phase)
        PH_IDLE:  if (launch) begin
                    phase   <= PH_ISSUE;
                    op_bank <= sw_bank;
                  end
        PH_ISSUE: phase <= PH_DONE;
        default:  phase <= PH_IDLE;
      endcase
    end
  end

  // data holding register: software load or read result
  always_ff @(posedge clk) begin
    if (rst) begin
      data_hold <= '0;
    end else if (data_wr) begin
      data_hold <= bus_wdata;
    end else if (phase == PH_DONE && !c_write) begin
      if (c_param) data_hold <= par_ok ? par_q : 32'd0;
      else         data_hold <= list_ok ? (ram_q & ENT_MASK) : 32'd0;
    end
  end

  gl_bank_ram #(.DEPTH(DEPTH), .W(32)) u_ram (
    .clk     (clk),
    .a_we    (ram_we),
    .a_addr  ({op_bank, c_addr[AW-1:0]}),
    .a_wdata (data_hold & ENT_MASK),
    .a_q     (ram_q),
    .b_addr  ({~sw_bank, sched_addr}),
    .b_q     (ram_bq)
  );

  gl_param_file #(.N(PARAM_N), .W(32)) u_par (
    .clk   (clk),
    .rst   (rst),
    .we    (par_we),
    .idx   (c_addr[PIW-1:0]),
    .wdata (data_hold),
    .q     (par_q)
  );

  assign sched_rdata = ram_bq & ENT_MASK;
  assign list_user   = c_sel;

  // register read port
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) begin
        case (bus_addr)
          RA_W'(REG_DATA): bus_rdata <= data_hold;
          RA_W'(REG_CTRL): bus_rdata <= {16'b0, c_addr, 4'b0, c_sel, c_param, c_write, busy};
          RA_W'(REG_STAT): bus_rdata <= {31'b0, sw_bank};
          default:         bus_rdata <= '0;
        endcase
      end
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^{bus_wdata[31:16], bus_wdata[7:4]};

  // R2: start stays up for exactly two cycles
  a_r2_busy_window: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |=> busy ##1 !busy);
  // R5: control fields frozen while an access runs
  a_r5_ctrl_frozen: assert property (@(posedge clk) disable iff (rst)
    (busy && bus_wr && bus_addr == RA_W'(REG_CTRL)) |=> ($stable(c_addr) && $stable(c_write)));
  // R7: no list write outside the configured depth
  a_r7_list_range: assert property (@(posedge clk) disable iff (rst)
    u_ram.a_we |-> ({24'b0, c_addr} < 32'(DEPTH)));
  // R8: swap toggles ownership
  a_r8_swap_toggles: assert property (@(posedge clk) disable iff (rst)
    swap_req |=> (sw_bank != $past(sw_bank)));
  // R3: reserved bits clear after a list access
  a_r3_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && !c_param && !c_write) |-> ((data_hold & ~ENT_MASK) == 32'd0));
  // R10: read strobe answered next cycle
  a_r10_rvalid: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid);
endmodule

// File: tb/gate_list_ctrl_tb.sv
module gate_list_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, swap_req = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [2:0]  sched_addr = '0;
  logic [31:0] bus_rdata, sched_rdata;
  logic        bus_rvalid, sw_bank, list_user;

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  gate_list_ctrl #(.DEPTH(8), .GATES(4), .TI_W(24), .RA_W(4)) u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .swap_req(swap_req), .sched_addr(sched_addr), .sched_rdata(sched_rdata),
    .sw_bank(sw_bank), .list_user(list_user));

  function automatic logic [31:0] mk(input logic [7:0] a, input bit wr, input bit par,
                                     input bit sel, input bit start);
    return {16'b0, a, 4'b0, sel, par, wr, start};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops scoreboard on each read response
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R10: actual=unexpected rvalid expected=none");
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(t, bus_rdata, e);
      end
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = 4'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, input logic [31:0] e, input string tag);
    bus_rd = 1'b1; bus_addr = 4'(a);
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic list_wr(input logic [7:0] a, input logic [31:0] d);
    wr(0, d); wr(1, mk(a, 1, 0, 0, 1)); idle(2);
  endtask

  task automatic list_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    wr(1, mk(a, 0, 0, 0, 1)); idle(2); rd(0, e, tag);
  endtask

  task automatic par_wr(input logic [7:0] a, input logic [31:0] d);
    wr(0, d); wr(1, mk(a, 1, 1, 0, 1)); idle(2);
  endtask

  task automatic par_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    wr(1, mk(a, 0, 1, 0, 1)); idle(2); rd(0, e, tag);
  endtask

  task automatic swap();
    swap_req = 1'b1; @(negedge clk); swap_req = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    chk("R1 sw_bank", {31'b0, sw_bank}, 32'd0);
    chk("R1 list_user", {31'b0, list_user}, 32'd0);
    chk("R1 rvalid", {31'b0, bus_rvalid}, 32'd0);
    rd(0, 32'd0, "R1 data");
    rd(1, 32'd0, "R1 ctrl");
    rd(2, 32'd0, "R1 status");

    // R3 entry layout and reserved masking
    list_wr(8'd1, 32'hFABC_DE12);
    list_rd(8'd1, 32'h0ABC_DE12, "R3 masked entry");
    list_wr(8'd2, 32'h0800_0064);
    list_rd(8'd2, 32'h0800_0064, "R3 gate3 interval");

    // R2 start bit timing
    wr(1, mk(8'd1, 0, 0, 0, 1));
    rd(1, mk(8'd1, 0, 0, 0, 1), "R2 busy cycle1");
    rd(1, mk(8'd1, 0, 0, 0, 1), "R2 busy cycle2");
    rd(1, mk(8'd1, 0, 0, 0, 0), "R2 start cleared");
    rd(0, 32'h0ABC_DE12, "R2 read result");

    // R5 control write during access ignored
    wr(0, 32'h0000_0777);
    wr(1, mk(8'd2, 0, 0, 0, 1));
    wr(1, mk(8'd1, 1, 0, 0, 1));
    idle(1);
    rd(1, mk(8'd2, 0, 0, 0, 0), "R5 ctrl unchanged");
    rd(0, 32'h0800_0064, "R5 first access result");
    list_rd(8'd1, 32'h0ABC_DE12, "R5 no second write");

    // R6 data write during access ignored
    wr(0, 32'h0100_0005);
    wr(1, mk(8'd3, 1, 0, 0, 1));
    wr(0, 32'h0F00_00FF);
    idle(1);
    rd(0, 32'h0100_0005, "R6 data hold kept");
    list_rd(8'd3, 32'h0100_0005, "R6 entry written");

    // R7 out-of-range list addresses
    list_wr(8'd0, 32'h0000_0042);
    list_wr(8'd7, 32'h0000_0077);
    list_wr(8'd8, 32'h0200_0001);
    list_wr(8'd255, 32'h0200_0002);
    list_rd(8'd0, 32'h0000_0042, "R7 alias of 8 untouched");
    list_rd(8'd7, 32'h0000_0077, "R7 alias of 255 untouched");
    list_rd(8'd8, 32'd0, "R7 oob read zero");
    list_rd(8'd255, 32'd0, "R7 oob read 255 zero");

    // R4 parameter words
    par_wr(8'd0, 32'hF122_3344);
    par_wr(8'd1, 32'h0000_1000);
    par_wr(8'd3, 32'h0000_0005);
    par_rd(8'd0, 32'hF122_3344, "R4 base time full width");
    par_rd(8'd1, 32'h0000_1000, "R4 cycle time");
    par_rd(8'd3, 32'h0000_0005, "R4 list length");
    par_rd(8'd2, 32'd0, "R4 extension untouched");
    list_rd(8'd0, 32'h0000_0042, "R4 list separate");
    par_wr(8'd4, 32'h0000_DEAD);
    par_rd(8'd0, 32'hF122_3344, "R7 param alias untouched");
    par_rd(8'd4, 32'd0, "R7 param oob zero");

    // R9 consumer select without start
    wr(1, mk(8'd0, 0, 0, 1, 0));
    chk("R9 list_user set", {31'b0, list_user}, 32'd1);
    rd(1, mk(8'd0, 0, 0, 1, 0), "R9 no launch");
    wr(1, mk(8'd0, 0, 0, 0, 0));
    chk("R9 list_user clear", {31'b0, list_user}, 32'd0);

    // R8 bank ownership
    sched_addr = 3'd0;
    swap();
    chk("R8 sw_bank after swap", {31'b0, sw_bank}, 32'd1);
    rd(2, 32'd1, "R8 status bit");
    idle(2);
    chk("R8 sched sees bank0", sched_rdata, 32'h0000_0042);
    list_wr(8'd0, 32'hF300_0009);
    list_rd(8'd0, 32'h0300_0009, "R8 sw bank1 entry");
    chk("R8 sched unaffected", sched_rdata, 32'h0000_0042);
    swap();
    chk("R8 sw_bank back", {31'b0, sw_bank}, 32'd0);
    idle(2);
    chk("R8 sched sees bank1", sched_rdata, 32'h0300_0009);
    list_rd(8'd0, 32'h0000_0042, "R8 sw bank0 entry");
    rd(2, 32'd0, "R8 status back");

    idle(4);
    chk("R10 all reads answered", 32'(exp_q.size()), 32'd0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule